// File: doc/BRIEF.md
# Window-Gated Incremental PID Duty Compensator

This block is the steady-state regulator of a dual-mode switching power supply controller. Once per switching period a signed error sample arrives together with a strobe. If the error lies within a small symmetric window around zero, the block advances an incremental (velocity-form) PID law. That law adds a weighted sum of the current error and the two previous errors to the last duty command. The new command is saturated to the modulator's legal range and registered. Small errors move the duty command only a little, so the state changes seldom in steady state.

When a sample falls outside the window, the block raises a transient flag and freezes. A separate fast transient controller then drives the power switch. Only when that controller signals a handback does the block resume. On handback it clears its error history and loads its duty register from a preset input, which normally carries the steady-state conversion ratio. It does not leave transient mode on its own.

Top module: `pid_gated_comp`

## Requirements
- R1: After reset the transient flag is 0 and the duty output is 0, and both error history stages hold 0.
- R2: On a sample strobe in linear mode with the error inside the window, the duty output on the next cycle is D + floor((KA*e0 + KB*e1 + KC*e2) / 2^FRAC). D is the previous duty, e0 the new error, e1 and e2 the two previously accepted errors, and KA, KB, KC signed two's-complement coefficients with FRAC fractional bits (default 4). The history then shifts: e2 takes e1 and e1 takes e0.
- R3: A computed duty above DMAX (default 1000) is registered as DMAX.
- R4: A computed duty below 0 is registered as 0.
- R5: The window is inclusive: errors from -WIN to +WIN (default 3) update normally. A sampled error of magnitude WIN+1 or more sets the transient flag on the next cycle and changes neither the duty nor the history.
- R6: While the transient flag is set, sample strobes change neither the duty output nor the history.
- R7: A handback strobe clears the transient flag, zeroes both history stages and loads the duty register with the preset input. A preset above DMAX is loaded as DMAX.
- R8: The transient flag stays set across any number of sample strobes, in-window errors included, until a handback strobe.
- R9: When handback and sample strobes coincide, the handback applies and the sample is discarded: it neither updates the duty nor enters the history.
- R10: Without a strobe, the duty output and the transient flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe: err_in holds a new error sample |
| err_in | input | EW (8) | Signed error sample |
| coef_a | input | CW (12) | Signed weight of the current error |
| coef_b | input | CW (12) | Signed weight of the previous error |
| coef_c | input | CW (12) | Signed weight of the error two samples back |
| rtn_stb | input | 1 | One-cycle strobe: transient controller returns control |
| rtn_duty | input | DW (10) | Preset duty loaded on handback |
| duty_out | output | DW (10) | Registered duty command, 0 to DMAX |
| xmode | output | 1 | High while the transient controller owns the switch |

## Verification
On every cycle, the assertions check several invariants. The duty output never exceeds DMAX. The duty and flag hold between strobes. The flag is sticky until a handback. An out-of-window sample raises the flag without moving the duty. A handback clears the flag and loads an in-range preset exactly. The exact arithmetic of the update law can be shown only by the bench's scenarios. These include floor rounding of negative increments, saturation at both ends, and clearing of the history. That clearing becomes visible only when a later sample with zero error leaves the duty unchanged despite nonzero history weights. The bench's scenarios also cover the inclusive window edges and the rule that a coincident sample is discarded.

// File: rtl/pidg_pkg.sv
package pidg_pkg;
  typedef enum logic {
    MODE_LIN  = 1'b0,
    MODE_XFER = 1'b1
  } mode_e;
endpackage

// File: rtl/pidg_mode_sel.sv
module pidg_mode_sel #(
  parameter int EW  = 8,
  parameter int WIN = 3
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 smp_stb,
  input  logic signed [EW-1:0] err_in,
  input  logic                 rtn_stb,
  output logic                 upd_en,
  output logic                 xmode
);
  import pidg_pkg::*;

  localparam logic signed [EW-1:0] WIN_P = EW'(WIN);
  localparam logic signed [EW-1:0] WIN_N = -EW'(WIN);

  mode_e mode_q, mode_d;
  logic  in_win;

  always_comb begin
    in_win = (err_in <= WIN_P) && (err_in >= WIN_N);
    mode_d = mode_q;
    upd_en = 1'b0;
    if (rtn_stb) begin
      mode_d = MODE_LIN;
    end else if (smp_stb && (mode_q == MODE_LIN)) begin
      if (in_win) upd_en = 1'b1;
      else        mode_d = MODE_XFER;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) mode_q <= MODE_LIN;
    else         mode_q <= mode_d;
  end

  assign xmode = (mode_q == MODE_XFER);

  // R8: transient mode is left only through a handback
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (xmode && !rtn_stb) |=> xmode);

  // R7: a handback always returns to linear mode
  p_rtn_lin_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    rtn_stb |=> !xmode);

  // R5: an out-of-window sample in linear mode enters transient mode
  p_enter_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_stb && !rtn_stb && !xmode && ((err_in > WIN_P) || (err_in < WIN_N))) |=> xmode);
endmodule

// File: rtl/pidg_history.sv
module pidg_history #(
  parameter int EW = 8
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 upd_en,
  input  logic                 clr,
  input  logic signed [EW-1:0] err_in,
  output logic signed [EW-1:0] e1,
  output logic signed [EW-1:0] e2
);
  logic signed [EW-1:0] e1_d, e2_d;
  logic                 ld;

  always_comb begin
    ld   = clr || upd_en;
    e1_d = e1;
    e2_d = e2;
    if (clr) begin
      e1_d = '0;
      e2_d = '0;
    end else if (upd_en) begin
      e1_d = err_in;
      e2_d = e1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      e1 <= '0;
      e2 <= '0;
    end else if (ld) begin
      e1 <= e1_d;
      e2 <= e2_d;
    end
  end

  // R7: history is zero right after a handback
  p_hist_clr_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    clr |=> (e1 == '0 && e2 == '0));

  // R6: history holds without an accepted sample
  p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr && !upd_en) |=> ($stable(e1) && $stable(e2)));
endmodule

// File: rtl/pidg_duty_calc.sv
module pidg_duty_calc #(
  parameter int EW   = 8,
  parameter int CW   = 12,
  parameter int FRAC = 4,
  parameter int DW   = 10,
  parameter int DMAX = 1000
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 upd_en,
  input  logic                 load,
  input  logic        [DW-1:0] preset,
  input  logic signed [EW-1:0] e0,
  input  logic signed [EW-1:0] e1,
  input  logic signed [EW-1:0] e2,
  input  logic signed [CW-1:0] ka,
  input  logic signed [CW-1:0] kb,
  input  logic signed [CW-1:0] kc,
  output logic        [DW-1:0] duty
);
  localparam int AW = EW + CW + 2;
  localparam int SW = ((AW > DW) ? AW : DW) + 2;
  localparam logic signed [SW-1:0] DMAX_S = SW'(DMAX);
  localparam logic        [DW-1:0] DMAX_U = DW'(DMAX);

  logic signed [AW-1:0] pa, pb, pc, acc, incr;
  logic signed [SW-1:0] sum_w;
  logic        [DW-1:0] sat_v, pre_v, duty_d;
  logic                 ld;

  always_comb begin
    pa    = AW'(ka) * AW'(e0);
    pb    = AW'(kb) * AW'(e1);
    pc    = AW'(kc) * AW'(e2);
    acc   = pa + pb + pc;
    incr  = acc >>> FRAC;
    sum_w = SW'(signed'({1'b0, duty})) + SW'(incr);
    if (sum_w < 0)           sat_v = '0;
    else if (sum_w > DMAX_S) sat_v = DMAX_U;
    else                     sat_v = sum_w[DW-1:0];
    pre_v  = (preset > DMAX_U) ? DMAX_U : preset;
    ld     = load || upd_en;
    duty_d = load ? pre_v : sat_v;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  duty <= '0;
    else if (ld)  duty <= duty_d;
  end

  // R3: the registered duty never exceeds the upper limit
  p_duty_max_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    duty <= DMAX_U);

  // R10: duty holds when neither update nor load is requested
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ld) |=> $stable(duty));

  // R7: an in-range preset is loaded exactly
  p_preset_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (load && preset <= DMAX_U) |=> (duty == $past(preset)));
endmodule

// File: rtl/pid_gated_comp.sv
module pid_gated_comp #(
  parameter int EW   = 8,
  parameter int CW   = 12,
  parameter int FRAC = 4,
  parameter int DW   = 10,
  parameter int DMAX = 1000,
  parameter int WIN  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [EW-1:0] err_in,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  input  logic                 rtn_stb,
  input  logic        [DW-1:0] rtn_duty,
  output logic        [DW-1:0] duty_out,
  output logic                 xmode
);
  logic [1:0] rst_sync;
  logic       rst_sn;
  logic       upd_en;
  logic signed [EW-1:0] e1, e2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  pidg_mode_sel #(.EW(EW), .WIN(WIN)) u_mode (
    .clk(clk), .rst_sn(rst_sn), .smp_stb(smp_stb), .err_in(err_in),
    .rtn_stb(rtn_stb), .upd_en(upd_en), .xmode(xmode)
  );

  pidg_history #(.EW(EW)) u_hist (
    .clk(clk), .rst_sn(rst_sn), .upd_en(upd_en), .clr(rtn_stb),
    .err_in(err_in), .e1(e1), .e2(e2)
  );

  pidg_duty_calc #(.EW(EW), .CW(CW), .FRAC(FRAC), .DW(DW), .DMAX(DMAX)) u_duty (
    .clk(clk), .rst_sn(rst_sn), .upd_en(upd_en), .load(rtn_stb),
    .preset(rtn_duty), .e0(err_in), .e1(e1), .e2(e2),
    .ka(coef_a), .kb(coef_b), .kc(coef_c), .duty(duty_out)
  );

  // R6: no duty movement while the transient controller owns the switch
  p_xhold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (xmode && !rtn_stb) |=> $stable(duty_out));

  // R5: the sample that leaves the window does not move the duty
  p_exit_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_stb && !rtn_stb && !xmode && (err_in > 3 || err_in < -3)) |=> $stable(duty_out));
endmodule

// File: tb/sim_pid_gated_comp.sv
module sim_pid_gated_comp;
  localparam int EW = 8, CW = 12, FRAC = 4, DW = 10, DMAX = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic rtn_stb = 1'b0;
  logic signed [EW-1:0] err_in = '0;
  logic signed [CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
  logic [DW-1:0] rtn_duty = '0;
  logic [DW-1:0] duty_out;
  logic xmode;

  int n_chk = 0, n_err = 0;
  int m_duty = 0, m_e1 = 0, m_e2 = 0, m_x = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pid_gated_comp u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .err_in(err_in),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .rtn_stb(rtn_stb), .rtn_duty(rtn_duty), .duty_out(duty_out), .xmode(xmode)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " duty"}, int'(duty_out), m_duty);
    chk({req, " mode"}, int'(xmode), m_x);
  endtask

  task automatic set_coefs(int a, int b, int c);
    coef_a = CW'(a); coef_b = CW'(b); coef_c = CW'(c);
  endtask

  // one sample strobe; the reference model follows R2..R6, R8
  task automatic sample(int e);
    int acc, nd;
    @(negedge clk);
    err_in = EW'(e); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    if (m_x == 0) begin
      if (e <= 3 && e >= -3) begin
        acc = int'(coef_a) * e + int'(coef_b) * m_e1 + int'(coef_c) * m_e2;
        nd  = m_duty + (acc >>> FRAC);
        if (nd > DMAX) nd = DMAX;
        if (nd < 0) nd = 0;
        m_duty = nd; m_e2 = m_e1; m_e1 = e;
      end else begin
        m_x = 1;
      end
    end
  endtask

  task automatic handback(int p, bit with_sample, int e);
    @(negedge clk);
    rtn_duty = DW'(p); rtn_stb = 1'b1;
    if (with_sample) begin err_in = EW'(e); smp_stb = 1'b1; end
    @(negedge clk);
    rtn_stb = 1'b0; smp_stb = 1'b0;
    m_x = 0; m_e1 = 0; m_e2 = 0;
    m_duty = (p > DMAX) ? DMAX : p;
  endtask

  task automatic t_reset;
    chk_state("R1 reset");
  endtask

  task automatic t_law;
    set_coefs(16, -8, 4);
    handback(500, 1'b0, 0);
    chk_state("R7 preset 500");
    sample(3);  chk_state("R2 e=3");
    sample(-2); chk_state("R2 e=-2 floor");
    sample(1);  chk_state("R2 e=1 history");
    chk(   "R2 value check", int'(duty_out), 501);
  endtask

  task automatic t_idle;
    repeat (6) @(negedge clk);
    chk_state("R10 idle");
  endtask

  task automatic t_window;
    sample(-3); chk_state("R5 edge -3");
    sample(4);  chk_state("R5 +4 exits");
    chk("R5 flag", int'(xmode), 1);
    sample(2);  chk_state("R6 R8 in-window in xmode");
    sample(-9); chk_state("R6 out-window in xmode");
    repeat (3) @(negedge clk);
    chk("R8 still transient", int'(xmode), 1);
    handback(300, 1'b0, 0);
    chk_state("R7 handback");
    sample(0);  chk_state("R7 history cleared");
    chk("R7 duty after zero sample", int'(duty_out), 300);
    sample(-4); chk_state("R5 -4 exits");
  endtask

  task automatic t_sat;
    set_coefs(160, 0, 0);
    handback(998, 1'b0, 0);
    sample(3);  chk_state("R3 high clamp");
    chk("R3 value", int'(duty_out), DMAX);
    handback(5, 1'b0, 0);
    sample(-3); chk_state("R4 low clamp");
    chk("R4 value", int'(duty_out), 0);
    handback(1023, 1'b0, 0);
    chk_state("R7 preset clamp");
  endtask

  task automatic t_coincide;
    set_coefs(16, -8, 4);
    sample(5); chk_state("R9 enter transient");
    handback(400, 1'b1, 3);
    chk_state("R9 handback wins");
    sample(0); chk_state("R9 sample not in history");
    chk("R9 value", int'(duty_out), 400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_law();
    t_idle();
    t_window();
    t_sat();
    t_coincide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule